// File: doc/BRIEF.md
# HDLC Frame Transmitter

This block turns a stream of bytes into a serial HDLC line. A byte source offers bytes on a valid/ready port, and each byte carries a start-of-frame and an end-of-frame marker. The block wraps every frame in flag bytes. It inserts a zero after runs of ones, so that the frame body can never look like a flag. It then appends a complemented frame check sequence. Between frames the line carries the selected fill. One output bit leaves per cycle in which the bit-clock enable is high.

Static configuration inputs set the following: a 16- or 32-bit check sequence, the CRC start value, host-supplied check bytes instead of generated ones, flag or all-ones fill, and the bit order within a byte. A transparent mode drops all framing and sends bytes raw. In that mode the line idles high when no byte is waiting.

Back-pressure rules: `s_ready` is a single-cycle pulse. It is raised only in a bit-enable cycle in which the transmitter takes a byte. A transfer happens when `s_valid` and `s_ready` are both high at a rising clock edge. Once `s_valid` is raised, the source must hold it and the byte fields steady until the transfer. A frame that has started needs each next byte by the time the current byte has been shifted out. If the byte is late, the frame is aborted.

Top module: `hdlc_tx_framer`

## Requirements
- R1: Reset values:
  - `tx_bit` is 1.
  - `s_ready` is 0.
- R2: Fill between frames in framed mode, as a function of `cfg_fill_flags`:
  - When `cfg_fill_flags`=0, the line carries continuous 1s.
  - When `cfg_fill_flags`=1, it carries back-to-back flags. A flag is 0x7E, sent on the line as 0,1,1,1,1,1,1,0.
- R3: Frame structure:
  - A byte offered with `s_sof`=1 while idle starts a frame.
  - The line carries an opening flag, then the contents, then the check sequence (unless R8 applies), then a closing flag.
  - The byte with `s_eof`=1 is the last content byte.
  - A byte offered while idle with `s_sof`=0 is accepted and dropped.
- R4: Zero stuffing:
  - After five consecutive 1s within the contents or the check sequence, a 0 is inserted.
  - Flags are never stuffed.
- R5: Bit order within a byte:
  - When `cfg_msb_first`=0, bit 0 of each byte goes out first.
  - When `cfg_msb_first`=1, bit 7 goes out first.
- R6: Check sequence:
  - `cfg_crc32`=1 selects CRC-32 (reflected polynomial 0xEDB88320).
  - `cfg_crc32`=0 selects CRC-16 (reflected polynomial 0x8408).
  - The CRC covers the content bits in line order, before stuffing.
  - It is complemented before it is sent, and its low-order bit goes out first.
- R7: CRC start value: the register starts at all ones when `cfg_crc_init_zero`=0, and at all zeros when it is 1.
- R8: With `cfg_crc_off`=1, no check sequence is generated. The host's final bytes are sent as the check field, followed directly by the closing flag.
- R9: Underrun abort:
  - If no byte is valid when a framed byte is due, the transmitter sends eight 1s.
  - It then returns to the selected fill.
- R10: Transparent mode (`cfg_transparent`=1):
  - Bytes are sent raw, with no flag, stuffing or check sequence.
  - The line is 1 whenever no byte is waiting.
  - `cfg_fill_flags`, `cfg_crc32`, `cfg_crc_init_zero` and `cfg_crc_off` have no effect.
- R11: Handshake and bit-clock timing:
  - `s_ready` is high only in cycles where `bit_en` is high.
  - `tx_bit` changes only on edges where `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-clock enable, one line bit per high cycle |
| cfg_transparent | input | 1 | Raw mode with no framing |
| cfg_fill_flags | input | 1 | Inter-frame fill: 0 gives ones, 1 gives flags |
| cfg_crc32 | input | 1 | 1 selects the 32-bit check sequence, 0 the 16-bit one |
| cfg_crc_init_zero | input | 1 | CRC start value: 0 gives all ones, 1 gives zeros |
| cfg_crc_off | input | 1 | Host supplies the check bytes |
| cfg_msb_first | input | 1 | Bit order within a byte |
| s_data | input | 8 | Byte offered |
| s_valid | input | 1 | Byte offered is valid |
| s_sof | input | 1 | Byte is the first of a frame |
| s_eof | input | 1 | Byte is the last of a frame |
| s_ready | output | 1 | Byte taken this cycle |
| tx_bit | output | 1 | Serial line output |

## Verification
Two functions can fall in the same bit slot: inserting a stuffed zero and fetching the next byte. Frames that end a byte with a run of ones force this case. Examples are 0xFF bytes, and 0xF8 followed by 0x1F in MSB-first order. The stuffed zero must then take the slot, and the handshake must slip by exactly one bit time. The bench builds the expected line stream from the requirements: flags, stuffing and check sequence. It then searches the captured bits for that exact sequence. A byte taken one slot early or late, or a missing zero, breaks the match. The bench also checks the check sequences against the published check values of "123456789" for both widths.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_OPEN,
    S_DATA,
    S_FCS,
    S_CLOSE,
    S_ABORT
  } tx_state_e;

  localparam int          BYTE_W   = 8;
  localparam int          CRC32_W  = 32;
  localparam int          CRC16_W  = 16;
  localparam logic [7:0]  FLAG_PAT = 8'h7E;
  localparam logic [31:0] POLY32   = 32'hEDB88320;
  localparam logic [31:0] POLY16   = 32'h00008408;

  // one reflected CRC step on a single line bit
  function automatic logic [31:0] crc_step(input logic [31:0] crc,
                                           input logic        b,
                                           input logic        wide);
    logic [31:0] nxt;
    nxt = crc >> 1;
    if (crc[0] ^ b) nxt = nxt ^ (wide ? POLY32 : POLY16);
    return nxt;
  endfunction

endpackage

// File: rtl/hdlc_crc_gen.sv
module hdlc_crc_gen
  import hdlc_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic upd,
  input  logic shift_out,
  input  logic din,
  input  logic wide,
  input  logic init_zero,
  output logic fcs_bit
);
  logic [CRC32_W-1:0] crc;
  logic [CRC32_W-1:0] init_val;

  always_comb begin
    if (init_zero)  init_val = '0;
    else if (wide)  init_val = '1;
    else            init_val = {{(CRC32_W-CRC16_W){1'b0}}, {CRC16_W{1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         crc <= '0;
    else if (init)      crc <= init_val;
    else if (upd)       crc <= crc_step(crc, din, wide);
    else if (shift_out) crc <= crc >> 1;
  end

  assign fcs_bit = ~crc[0];

  // R6: in 16-bit mode the upper half never fills
  p_crc16_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && $past(!wide) && $past(init || upd || shift_out)) |-> (crc[31:16] == '0 || $past(crc[31:16] != '0)));

endmodule

// File: rtl/hdlc_bit_stuffer.sv
module hdlc_bit_stuffer #(
  parameter int MAX_ONES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic raw_bit,
  input  logic stuffable,
  output logic hold,
  output logic tx_bit
);
  localparam int OW = $clog2(MAX_ONES + 1);
  logic [OW-1:0] ones;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones   <= '0;
      hold   <= 1'b0;
      tx_bit <= 1'b1;
    end else if (bit_en) begin
      if (hold) begin
        tx_bit <= 1'b0;
        ones   <= '0;
        hold   <= 1'b0;
      end else begin
        tx_bit <= raw_bit;
        if (stuffable && raw_bit) begin
          ones <= ones + 1'b1;
          hold <= (ones == OW'(MAX_ONES - 1));
        end else begin
          ones <= '0;
        end
      end
    end
  end

  p_stuff_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && bit_en) |=> !tx_bit);
  p_ones_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= OW'(MAX_ONES));
  p_line_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
#(
  parameter int ABORT_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              step,
  input  logic              transp,
  input  logic              fill_flags,
  input  logic              crc32,
  input  logic              crc_off,
  input  logic              msb_first,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_sof,
  input  logic              s_eof,
  output logic              s_ready,
  input  logic              crc_bit,
  output logic              raw_bit,
  output logic              stuffable,
  output logic              crc_init,
  output logic              crc_upd,
  output logic              crc_out,
  output logic              is_idle
);
  localparam int CNT_W = $clog2(CRC32_W);

  tx_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sr;
  logic              eof_l;
  logic              take, fire, byte_end, abort_end, fcs_end, data_bit;

  assign byte_end  = (cnt == CNT_W'(BYTE_W - 1));
  assign abort_end = (cnt == CNT_W'(ABORT_LEN - 1));
  assign fcs_end   = (cnt == (crc32 ? CNT_W'(CRC32_W - 1) : CNT_W'(CRC16_W - 1)));

  generate
    if (BYTE_W > 1) begin : g_order
      assign data_bit = msb_first ? sr[BYTE_W-1] : sr[0];
    end else begin : g_single
      assign data_bit = sr[0];
    end
  endgenerate

  always_comb begin
    raw_bit   = 1'b1;
    stuffable = 1'b0;
    take      = 1'b0;
    case (st)
      S_IDLE:  begin
        raw_bit = (fill_flags && !transp) ? FLAG_PAT[cnt[2:0]] : 1'b1;
        take    = byte_end && (transp || !s_sof);
      end
      S_OPEN:  begin
        raw_bit = FLAG_PAT[cnt[2:0]];
        take    = byte_end;
      end
      S_DATA:  begin
        raw_bit   = data_bit;
        stuffable = !transp;
        take      = byte_end && (transp || !eof_l);
      end
      S_FCS:   begin
        raw_bit   = crc_bit;
        stuffable = 1'b1;
      end
      S_CLOSE: raw_bit = FLAG_PAT[cnt[2:0]];
      default: raw_bit = 1'b1;
    endcase
  end

  assign s_ready  = step && take;
  assign fire     = s_ready && s_valid;
  assign crc_init = step && (st == S_IDLE) && byte_end && !transp && s_valid && s_sof;
  assign crc_upd  = step && (st == S_DATA) && !transp;
  assign crc_out  = step && (st == S_FCS);
  assign is_idle  = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      sr    <= '0;
      eof_l <= 1'b0;
    end else if (step) begin
      cnt <= cnt + 1'b1;
      case (st)
        S_IDLE: if (byte_end) begin
          cnt <= '0;
          if (transp) begin
            if (fire) begin sr <= s_data; eof_l <= 1'b0; st <= S_DATA; end
          end else if (s_valid && s_sof) begin
            st <= S_OPEN;
          end
        end
        S_OPEN: if (byte_end) begin
          cnt <= '0;
          if (fire) begin sr <= s_data; eof_l <= s_eof; st <= S_DATA; end
          else st <= S_ABORT;
        end
        S_DATA: begin
          sr <= msb_first ? (sr << 1) : (sr >> 1);
          if (byte_end) begin
            cnt <= '0;
            if (transp) begin
              if (fire) begin sr <= s_data; eof_l <= 1'b0; end
              else st <= S_IDLE;
            end else if (eof_l) begin
              st <= crc_off ? S_CLOSE : S_FCS;
            end else if (fire) begin
              sr <= s_data; eof_l <= s_eof;
            end else begin
              st <= S_ABORT;
            end
          end
        end
        S_FCS:   if (fcs_end)   begin cnt <= '0; st <= S_CLOSE; end
        S_CLOSE: if (byte_end)  begin cnt <= '0; st <= S_IDLE;  end
        S_ABORT: if (abort_end) begin cnt <= '0; st <= S_IDLE;  end
        default: begin cnt <= '0; st <= S_IDLE; end
      endcase
    end
  end

  p_ready_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> bit_en);
  p_no_fcs_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && crc_off && !transp && eof_l && byte_end && step) |=> (st == S_CLOSE));
  p_abort_then_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ABORT && abort_end && step) |=> (st == S_IDLE));

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int ABORT_LEN = 8,
  parameter int MAX_ONES  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              cfg_transparent,
  input  logic              cfg_fill_flags,
  input  logic              cfg_crc32,
  input  logic              cfg_crc_init_zero,
  input  logic              cfg_crc_off,
  input  logic              cfg_msb_first,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_sof,
  input  logic              s_eof,
  output logic              s_ready,
  output logic              tx_bit
);
  logic hold, step, raw_bit, stuffable, crc_init, crc_upd, crc_out, crc_bit, is_idle;

  assign step = bit_en && !hold;

  hdlc_tx_ctrl #(.ABORT_LEN(ABORT_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .step(step),
    .transp(cfg_transparent), .fill_flags(cfg_fill_flags), .crc32(cfg_crc32),
    .crc_off(cfg_crc_off), .msb_first(cfg_msb_first),
    .s_data(s_data), .s_valid(s_valid), .s_sof(s_sof), .s_eof(s_eof), .s_ready(s_ready),
    .crc_bit(crc_bit), .raw_bit(raw_bit), .stuffable(stuffable),
    .crc_init(crc_init), .crc_upd(crc_upd), .crc_out(crc_out), .is_idle(is_idle)
  );

  hdlc_crc_gen u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .upd(crc_upd), .shift_out(crc_out),
    .din(raw_bit), .wide(cfg_crc32), .init_zero(cfg_crc_init_zero), .fcs_bit(crc_bit)
  );

  hdlc_bit_stuffer #(.MAX_ONES(MAX_ONES)) u_stuff (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .raw_bit(raw_bit),
    .stuffable(stuffable), .hold(hold), .tx_bit(tx_bit)
  );

  p_transp_idle_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_transparent && is_idle && step) |=> tx_bit);
  p_ones_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fill_flags && is_idle && step) |=> tx_bit);

endmodule

// File: tb/hdlc_tx_framer_test.sv
module hdlc_tx_framer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic cfg_transparent = 1'b0, cfg_fill_flags = 1'b0, cfg_crc32 = 1'b0;
  logic cfg_crc_init_zero = 1'b0, cfg_crc_off = 1'b0, cfg_msb_first = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0;
  logic s_ready, tx_bit;

  hdlc_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .cfg_transparent(cfg_transparent), .cfg_fill_flags(cfg_fill_flags),
    .cfg_crc32(cfg_crc32), .cfg_crc_init_zero(cfg_crc_init_zero),
    .cfg_crc_off(cfg_crc_off), .cfg_msb_first(cfg_msb_first),
    .s_data(s_data), .s_valid(s_valid), .s_sof(s_sof), .s_eof(s_eof),
    .s_ready(s_ready), .tx_bit(tx_bit)
  );

  always #2 clk = ~clk;

  // cfg {msb_first, crc_off, init_zero, crc32, fill_flags}, length, up to four bytes
  localparam logic [39:0] VEC [0:6] = '{
    {5'b00000, 3'd3, 32'h11223300},
    {5'b00001, 3'd4, 32'hFFFF7E00},
    {5'b00010, 3'd2, 32'hA55A0000},
    {5'b00100, 3'd3, 32'h0180FF00},
    {5'b10000, 3'd2, 32'hF81F0000},
    {5'b01000, 3'd4, 32'hC33CFFFC},
    {5'b10110, 3'd1, 32'h7E000000}
  };

  int n_chk = 0, n_bad = 0, r11_bad = 0, ph = 0, cap_n = 0, exp_n = 0, cb_n = 0;
  logic en_d = 1'b0;
  logic done = 1'b0;
  logic cap [0:4095];
  logic expb [0:1023];
  logic cb [0:511];
  logic [7:0] bb [0:15];

  // bit-clock enable: two of every three cycles; capture line bits
  always @(negedge clk) begin
    if (rst_n && en_d && cap_n < 4096) begin cap[cap_n] = tx_bit; cap_n++; end
    ph = (ph == 2) ? 0 : ph + 1;
    bit_en = rst_n && (ph != 2);
    en_d = bit_en;
  end

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic sof, input logic eof);
    @(negedge clk);
    s_data = b; s_sof = sof; s_eof = eof; s_valid = 1'b1;
    #1;
    while (!s_ready) begin @(negedge clk); #1; end
    if (!bit_en) r11_bad++;
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic add_byte(input logic [7:0] b, input logic msb);
    for (int i = 0; i < 8; i++) begin cb[cb_n] = msb ? b[7-i] : b[i]; cb_n++; end
  endtask

  task automatic add_flag();
    for (int i = 0; i < 8; i++) begin expb[exp_n] = (i != 0 && i != 7); exp_n++; end
  endtask

  task automatic stuff_cb();
    int ones;
    ones = 0;
    for (int i = 0; i < cb_n; i++) begin
      expb[exp_n] = cb[i]; exp_n++;
      ones = cb[i] ? ones + 1 : 0;
      if (ones == 5) begin expb[exp_n] = 1'b0; exp_n++; ones = 0; end
    end
  endtask

  // content bits from bb[0..n-1] plus an optional computed check sequence
  task automatic build_cb(input int n, input logic msb, input logic off,
                          input logic init0, input logic c32);
    logic [31:0] c;
    int dn;
    cb_n = 0;
    for (int i = 0; i < n; i++) add_byte(bb[i], msb);
    dn = cb_n;
    c = init0 ? 32'h0 : (c32 ? 32'hFFFFFFFF : 32'h0000FFFF);
    for (int i = 0; i < dn; i++) begin
      if (c[0] ^ cb[i]) c = (c >> 1) ^ (c32 ? 32'hEDB88320 : 32'h00008408);
      else c = c >> 1;
    end
    if (!off) for (int i = 0; i < (c32 ? 32 : 16); i++) begin cb[cb_n] = ~c[i]; cb_n++; end
  endtask

  function automatic logic found();
    for (int s = 0; s + exp_n <= cap_n; s++) begin
      logic ok;
      ok = 1'b1;
      for (int k = 0; k < exp_n; k++) if (cap[s+k] !== expb[k]) ok = 1'b0;
      if (ok) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic int zeros(input int first, input int n);
    int z;
    z = 0;
    for (int i = first; i < first + n; i++) if (cap[i] === 1'b0) z++;
    return z;
  endfunction

  task automatic send(input int n, input logic with_eof, input logic framed);
    for (int i = 0; i < n; i++) push(bb[i], framed && (i == 0), with_eof && (i == n - 1));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    // R1: reset state
    wait_cyc(4);
    check(tx_bit === 1'b1, "R1 tx_bit in reset", int'(tx_bit), 1);
    check(s_ready === 1'b0, "R1 s_ready in reset", int'(s_ready), 0);
    rst_n = 1'b1;
    wait_cyc(2);
    check(tx_bit === 1'b1, "R1 tx_bit after reset", int'(tx_bit), 1);

    // table of framed vectors: R3 R4 R5 R6 R7 R8
    foreach (VEC[v]) begin
      {cfg_msb_first, cfg_crc_off, cfg_crc_init_zero, cfg_crc32, cfg_fill_flags} = VEC[v][39:35];
      wait_cyc(40);
      for (int i = 0; i < 4; i++) bb[i] = VEC[v][31 - 8*i -: 8];
      cap_n = 0;
      send(int'(VEC[v][34:32]), 1'b1, 1'b1);
      wait_cyc(300);
      build_cb(int'(VEC[v][34:32]), cfg_msb_first, cfg_crc_off, cfg_crc_init_zero, cfg_crc32);
      exp_n = 0; add_flag(); stuff_cb(); add_flag();
      check(found(), $sformatf("R3 R4 R5 R6 R7 R8 frame vector %0d", v), 0, 1);
    end
    {cfg_msb_first, cfg_crc_off, cfg_crc_init_zero, cfg_crc32, cfg_fill_flags} = 5'b00000;

    // R2: ones fill
    wait_cyc(30); cap_n = 0; wait_cyc(120);
    check(zeros(0, 64) == 0, "R2 ones fill zero count", zeros(0, 64), 0);
    // R2: flag fill, two zeros per flag
    cfg_fill_flags = 1'b1;
    wait_cyc(30); cap_n = 0; wait_cyc(120);
    check(zeros(0, 64) == 16, "R2 flag fill zero count", zeros(0, 64), 16);

    // R10: transparent idles high even with flag fill selected
    cfg_transparent = 1'b1; cfg_crc32 = 1'b1; cfg_crc_off = 1'b1;
    wait_cyc(30); cap_n = 0; wait_cyc(120);
    check(zeros(0, 64) == 0, "R10 transparent idle ignores fill", zeros(0, 64), 0);
    // R10: raw bytes, no flags, stuffing or check sequence
    bb[0] = 8'hFF; bb[1] = 8'h3C; bb[2] = 8'hFE;
    cap_n = 0;
    send(3, 1'b1, 1'b0);
    wait_cyc(200);
    cb_n = 0; add_byte(bb[0], 1'b0); add_byte(bb[1], 1'b0); add_byte(bb[2], 1'b0);
    exp_n = 0; for (int i = 0; i < cb_n; i++) begin expb[exp_n] = cb[i]; exp_n++; end
    check(found(), "R10 transparent raw bits", 0, 1);
    check(zeros(0, cap_n) == 5, "R10 transparent zero count", zeros(0, cap_n), 5);
    cfg_transparent = 1'b0; cfg_crc32 = 1'b0; cfg_crc_off = 1'b0;
    wait_cyc(40);

    // R9: underrun abort then flag fill
    bb[0] = 8'h12; bb[1] = 8'h34;
    cap_n = 0;
    send(2, 1'b0, 1'b1);
    wait_cyc(200);
    cb_n = 0; add_byte(bb[0], 1'b0); add_byte(bb[1], 1'b0);
    exp_n = 0; add_flag(); stuff_cb();
    for (int i = 0; i < 8; i++) begin expb[exp_n] = 1'b1; exp_n++; end
    add_flag();
    check(found(), "R9 abort ones then fill", 0, 1);

    // R3: byte without start marker while idle is dropped
    cfg_fill_flags = 1'b0;
    wait_cyc(40);
    cap_n = 0;
    push(8'h00, 1'b0, 1'b1);
    wait_cyc(120);
    check(zeros(0, cap_n) == 0, "R3 byte without sof dropped", zeros(0, cap_n), 0);

    // R6: published check values of "123456789"
    for (int i = 0; i < 9; i++) bb[i] = 8'h31 + 8'(i);
    for (int w = 0; w < 2; w++) begin
      cfg_crc32 = (w == 1);
      wait_cyc(40);
      cap_n = 0;
      send(9, 1'b1, 1'b1);
      wait_cyc(400);
      cb_n = 0;
      for (int i = 0; i < 9; i++) add_byte(bb[i], 1'b0);
      if (w == 0) begin add_byte(8'h6E, 1'b0); add_byte(8'h90, 1'b0); end
      else begin
        add_byte(8'h26, 1'b0); add_byte(8'h39, 1'b0);
        add_byte(8'hF4, 1'b0); add_byte(8'hCB, 1'b0);
      end
      exp_n = 0; add_flag(); stuff_cb(); add_flag();
      check(found(), w == 0 ? "R6 CRC-16 check value" : "R6 CRC-32 check value", 0, 1);
    end

    // R11: every handshake fell in a bit-enable cycle
    check(r11_bad == 0, "R11 ready only with bit_en", r11_bad, 0);
    finish_run();
  end
endmodule